// File: doc/BRIEF.md
# Upward-Growing Stack Pointer with Limit and Floor Traps

This unit owns the stack pointer of a 16-bit data space and turns push, pop, subroutine-call and exception strobes into word accesses on a word-wide data RAM. The pointer always names the next free word and moves upward: a push writes at the pointer and then steps it by two, a pop steps it down by two and then reads there. Each accepted request shows on the RAM outputs one cycle after its strobe.

A limit register, written by firmware, bounds how high the stack may grow. A push at an address equal to the limit is allowed, and the push after that is refused with an overflow trap. A pop that would take the pointer below the protected floor at 0x0800 is refused with an underflow trap. Calls and exceptions save a 23-bit return address as two words over two cycles. On an exception the second word also carries an 8-bit status byte. The instruction decoder, the trap vectoring and the RAM itself sit outside this block.

Top module: `sp_stack_unit`

## Requirements
- R1: After reset all outputs are 0 and the stack pointer is 0x0800, so the first push writes to address 0x0800.
- R2: An accepted push drives ram_we_o high for one cycle, with ram_addr_o set to the pointer and ram_wdata_o set to push_data_i. The pointer then advances by 2.
- R3: An accepted pop drives ram_re_o high for one cycle, with ram_addr_o set to the pointer minus 2. The pointer then drops by 2.
- R4: Once the limit is valid, a push whose address equals the limit is written. A push whose address is greater than the limit raises ovf_trap_o instead. The stored limit has bit 0 forced to 0.
- R5: Until the first limit write after reset, no push raises ovf_trap_o.
- R6: A pop raises unf_trap_o when the pointer minus 2 would fall below 0x0800.
- R7: A trap is a pulse of one cycle per refused operation. No RAM write or read is issued for that operation and the pointer does not move.
- R8: A call writes two words on consecutive cycles. The first is ret_pc_i[15:0]. The second holds ret_pc_i[22:16] in bits 6:0 and 0 in bits 15:7. busy_o is high during the cycle in which the second word is issued.
- R9: An exception writes the same two words as a call, except that bits 15:8 of the second word hold status_i. Bit 7 of that word is 0.
- R10: When strobes arrive together, the priority is exception, then call, then push, then pop. All strobes are ignored while busy_o is high.
- R11: A limit write that arrives in the same cycle as a push or a call is applied before that operation's overflow check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push one data word |
| pop_i | input | 1 | Pop one word |
| call_i | input | 1 | Save a return address as two words |
| exc_i | input | 1 | Save a return address and status as two words |
| push_data_i | input | 16 | Data for a plain push |
| ret_pc_i | input | 23 | Return address for a call or exception |
| status_i | input | 8 | Status byte for an exception |
| lim_we_i | input | 1 | Write the limit register |
| lim_data_i | input | 16 | New limit value (bit 0 ignored) |
| busy_o | output | 1 | Second word of a frame is being issued; strobes ignored |
| ram_addr_o | output | 16 | RAM byte address |
| ram_wdata_o | output | 16 | RAM write data |
| ram_we_o | output | 1 | RAM write strobe |
| ram_re_o | output | 1 | RAM read strobe |
| ovf_trap_o | output | 1 | Stack overflow trap pulse |
| unf_trap_o | output | 1 | Stack underflow trap pulse |

## Verification
The pointer cannot be seen directly, so a wrong value shows up as a wrong RAM address on the very next push or pop, one cycle after that strobe. A lost limit-valid flag, or an off-by-one limit compare, shows up as a trap pulse in the wrong place, either on the push that lands at the limit or on the one after it. A bad frame sequencer shows up in busy_o or in the second written word. It can also show up as a later push landing two bytes off, because the pointer drifted.

// File: rtl/sp_pkg.sv
package sp_pkg;

   typedef enum logic [1:0] {
      SP_OP_NONE = 2'd0,
      SP_OP_PUSH = 2'd1,
      SP_OP_POP  = 2'd2
   } sp_op_e;

   localparam int unsigned SP_STEP_BYTES = 2;

endpackage

// File: rtl/sp_limit_reg.sv
module sp_limit_reg #(
   parameter int unsigned AW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          we_i,
   input  logic [AW-1:0] data_i,
   output logic [AW-1:0] lim_o,
   output logic          valid_o
);

   logic [AW-1:0] lim_q;
   logic          valid_q;
   logic [AW-1:0] lim_aligned;

   assign lim_aligned = {data_i[AW-1:1], 1'b0};

   // Limit storage carries no reset value; the valid flag guards its use.
   always_ff @(posedge clk) begin
      if (we_i) begin
         lim_q <= lim_aligned;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
      end else if (we_i) begin
         valid_q <= 1'b1;
      end
   end

   // Write-first view: a same-cycle write is what the operation sees.
   assign lim_o   = we_i ? lim_aligned : lim_q;
   assign valid_o = we_i | valid_q;

endmodule

// File: rtl/sp_trap_check.sv
module sp_trap_check
   import sp_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned SP_FLOOR = 16'h0800
) (
   input  sp_op_e        op_i,
   input  logic [AW-1:0] sp_i,
   input  logic [AW-1:0] lim_i,
   input  logic          lim_valid_i,
   output logic          ovf_o,
   output logic          unf_o
);

   localparam logic [AW:0] FLOOR_PLUS_STEP = (AW+1)'(SP_FLOOR + SP_STEP_BYTES);

   logic below_floor;

   generate
      if (SP_FLOOR == 0) begin : g_no_floor
         assign below_floor = (sp_i < AW'(SP_STEP_BYTES));
      end else begin : g_floor
         assign below_floor = ({1'b0, sp_i} < FLOOR_PLUS_STEP);
      end
   endgenerate

   assign ovf_o = (op_i == SP_OP_PUSH) && lim_valid_i && (sp_i > lim_i);
   assign unf_o = (op_i == SP_OP_POP) && below_floor;

endmodule

// File: rtl/sp_frame_fmt.sv
module sp_frame_fmt #(
   parameter int unsigned AW   = 16,
   parameter int unsigned PC_W = 23,
   parameter int unsigned ST_W = 8
) (
   input  logic [PC_W-1:0] pc_i,
   input  logic [ST_W-1:0] status_i,
   input  logic            exc_i,
   output logic [AW-1:0]   lo_o,
   output logic [AW-1:0]   hi_o
);

   localparam int unsigned HI_PC_W = PC_W - AW;
   localparam int unsigned GAP_W   = AW - HI_PC_W - ST_W;

   assign lo_o = pc_i[AW-1:0];

   generate
      if (ST_W == 0) begin : g_no_status
         assign hi_o = {{(AW-HI_PC_W){1'b0}}, pc_i[PC_W-1:AW]};
      end else if (GAP_W == 0) begin : g_status_tight
         assign hi_o = {(exc_i ? status_i : {ST_W{1'b0}}), pc_i[PC_W-1:AW]};
      end else begin : g_status_gap
         assign hi_o = {(exc_i ? status_i : {ST_W{1'b0}}),
                        {GAP_W{1'b0}}, pc_i[PC_W-1:AW]};
      end
   endgenerate

endmodule

// File: rtl/sp_stack_unit.sv
module sp_stack_unit
   import sp_pkg::*;
#(
   parameter int unsigned AW       = 16,
   parameter int unsigned PC_W     = 23,
   parameter int unsigned ST_W     = 8,
   parameter int unsigned SP_RESET = 16'h0800,
   parameter int unsigned SP_FLOOR = 16'h0800
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            push_i,
   input  logic            pop_i,
   input  logic            call_i,
   input  logic            exc_i,
   input  logic [AW-1:0]   push_data_i,
   input  logic [PC_W-1:0] ret_pc_i,
   input  logic [ST_W-1:0] status_i,
   input  logic            lim_we_i,
   input  logic [AW-1:0]   lim_data_i,
   output logic            busy_o,
   output logic [AW-1:0]   ram_addr_o,
   output logic [AW-1:0]   ram_wdata_o,
   output logic            ram_we_o,
   output logic            ram_re_o,
   output logic            ovf_trap_o,
   output logic            unf_trap_o
);

   localparam logic [AW-1:0] STEP     = AW'(SP_STEP_BYTES);
   localparam logic [AW-1:0] SP_INIT  = AW'(SP_RESET);

   generate
      if (PC_W <= AW || PC_W > 2*AW) begin : g_bad_pc
         $error("sp_stack_unit: PC_W must fit in two words and exceed one");
      end
      if ((PC_W - AW) + ST_W > AW) begin : g_bad_status
         $error("sp_stack_unit: status and upper PC bits exceed one word");
      end
      if ((SP_RESET % 2) != 0 || (SP_FLOOR % 2) != 0) begin : g_bad_align
         $error("sp_stack_unit: reset pointer and floor must be word-aligned");
      end
      if (SP_RESET < SP_FLOOR) begin : g_bad_reset
         $error("sp_stack_unit: reset pointer lies below the floor");
      end
   endgenerate

   logic [AW-1:0] sp_q;
   logic          pend_q;
   logic [AW-1:0] hi_q;

   logic [AW-1:0] lim_eff;
   logic          lim_valid;
   logic [AW-1:0] frame_lo;
   logic [AW-1:0] frame_hi;
   logic          ovf;
   logic          unf;

   sp_op_e        op;
   logic [AW-1:0] wdata;
   logic          frame_start;

   sp_limit_reg #(.AW(AW)) u_limit (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (lim_we_i),
      .data_i  (lim_data_i),
      .lim_o   (lim_eff),
      .valid_o (lim_valid)
   );

   sp_frame_fmt #(.AW(AW), .PC_W(PC_W), .ST_W(ST_W)) u_frame (
      .pc_i     (ret_pc_i),
      .status_i (status_i),
      .exc_i    (exc_i),
      .lo_o     (frame_lo),
      .hi_o     (frame_hi)
   );

   sp_trap_check #(.AW(AW), .SP_FLOOR(SP_FLOOR)) u_trap (
      .op_i        (op),
      .sp_i        (sp_q),
      .lim_i       (lim_eff),
      .lim_valid_i (lim_valid),
      .ovf_o       (ovf),
      .unf_o       (unf)
   );

   // Request arbitration: pending second word, then exception, call, push, pop.
   always_comb begin
      op          = SP_OP_NONE;
      wdata       = '0;
      frame_start = 1'b0;
      if (pend_q) begin
         op    = SP_OP_PUSH;
         wdata = hi_q;
      end else if (exc_i || call_i) begin
         op          = SP_OP_PUSH;
         wdata       = frame_lo;
         frame_start = 1'b1;
      end else if (push_i) begin
         op    = SP_OP_PUSH;
         wdata = push_data_i;
      end else if (pop_i) begin
         op = SP_OP_POP;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sp_q        <= SP_INIT;
         pend_q      <= 1'b0;
         hi_q        <= '0;
         ram_addr_o  <= '0;
         ram_wdata_o <= '0;
         ram_we_o    <= 1'b0;
         ram_re_o    <= 1'b0;
         ovf_trap_o  <= 1'b0;
         unf_trap_o  <= 1'b0;
      end else begin
         ram_we_o    <= 1'b0;
         ram_re_o    <= 1'b0;
         ram_wdata_o <= '0;
         ovf_trap_o  <= ovf;
         unf_trap_o  <= unf;
         pend_q      <= frame_start && !ovf;
         if (frame_start) begin
            hi_q <= frame_hi;
         end
         if (op == SP_OP_PUSH && !ovf) begin
            ram_we_o    <= 1'b1;
            ram_addr_o  <= sp_q;
            ram_wdata_o <= wdata;
            sp_q        <= sp_q + STEP;
         end else if (op == SP_OP_POP && !unf) begin
            ram_re_o   <= 1'b1;
            ram_addr_o <= sp_q - STEP;
            sp_q       <= sp_q - STEP;
         end
      end
   end

   assign busy_o = pend_q;

endmodule

// File: rtl/sp_stack_unit_chk.sv
module sp_stack_unit_chk #(
   parameter int unsigned AW       = 16,
   parameter int unsigned SP_FLOOR = 16'h0800
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy_o,
   input logic          ram_we_o,
   input logic          ram_re_o,
   input logic [AW-1:0] ram_addr_o,
   input logic          ovf_trap_o,
   input logic          unf_trap_o,
   input logic [AW-1:0] sp_q,
   input logic          lim_valid
);

   localparam logic [AW-1:0] TWO   = AW'(2);
   localparam logic [AW-1:0] FLOOR = AW'(SP_FLOOR);

   // R2: after a write the pointer sits one word above the written address
   p_push_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      ram_we_o |-> (sp_q == ram_addr_o + TWO));

   // R3: after a read the pointer equals the read address
   p_pop_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re_o |-> (sp_q == ram_addr_o));

   // R5: no overflow trap before the limit is valid
   p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !lim_valid |=> !ovf_trap_o);

   // R6: reads never land below the floor
   p_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
      ram_re_o |-> (ram_addr_o >= FLOOR));

   // R7: a trapping operation issues no RAM access
   p_trap_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_trap_o || unf_trap_o) |-> !(ram_we_o || ram_re_o));

   // R7: one operation raises at most one kind of trap
   p_one_trap_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovf_trap_o && unf_trap_o));

   // R8: the second word is either written or refused, and busy lasts one cycle
   p_second_word_r8: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |=> ((ram_we_o || ovf_trap_o) && !busy_o));

   // R2, R3: every access is word-aligned
   p_aligned_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ram_we_o || ram_re_o) |-> (ram_addr_o[0] == 1'b0));

endmodule

bind sp_stack_unit sp_stack_unit_chk #(.AW(AW), .SP_FLOOR(SP_FLOOR)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .busy_o     (busy_o),
   .ram_we_o   (ram_we_o),
   .ram_re_o   (ram_re_o),
   .ram_addr_o (ram_addr_o),
   .ovf_trap_o (ovf_trap_o),
   .unf_trap_o (unf_trap_o),
   .sp_q       (sp_q),
   .lim_valid  (lim_valid)
);

// File: tb/sp_stack_unit_test.sv
module sp_stack_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_i = 0, pop_i = 0, call_i = 0, exc_i = 0, lim_we_i = 0;
   logic [15:0] push_data_i = '0;
   logic [22:0] ret_pc_i = '0;
   logic [7:0]  status_i = '0;
   logic [15:0] lim_data_i = '0;
   logic        busy_o, ram_we_o, ram_re_o, ovf_trap_o, unf_trap_o;
   logic [15:0] ram_addr_o, ram_wdata_o;

   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   // Behavioural reference state
   int m_sp, m_lim, m_hi;
   bit m_lv, m_pend;
   bit e_we, e_re, e_ovf, e_unf;
   int e_addr, e_wd;

   always #5 clk = ~clk;

   sp_stack_unit uut (
      .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
      .call_i(call_i), .exc_i(exc_i), .push_data_i(push_data_i),
      .ret_pc_i(ret_pc_i), .status_i(status_i), .lim_we_i(lim_we_i),
      .lim_data_i(lim_data_i), .busy_o(busy_o), .ram_addr_o(ram_addr_o),
      .ram_wdata_o(ram_wdata_o), .ram_we_o(ram_we_o), .ram_re_o(ram_re_o),
      .ovf_trap_o(ovf_trap_o), .unf_trap_o(unf_trap_o)
   );

   task automatic model_step();
      int wd;
      bit is_push, is_pop, first;
      e_we = 0; e_re = 0; e_ovf = 0; e_unf = 0; e_addr = -1; e_wd = -1;
      is_push = 0; is_pop = 0; first = 0; wd = 0;
      if (lim_we_i) begin
         m_lim = int'(lim_data_i) & 16'hFFFE;
         m_lv  = 1;
      end
      if (m_pend) begin
         is_push = 1; wd = m_hi;
      end else if (exc_i || call_i) begin
         is_push = 1; first = 1;
         wd = int'(ret_pc_i) & 16'hFFFF;
         m_hi = (int'(ret_pc_i) >> 16) & 16'h7F;
         if (exc_i) m_hi = m_hi + int'(status_i) * 256;
      end else if (push_i) begin
         is_push = 1; wd = int'(push_data_i);
      end else if (pop_i) begin
         is_pop = 1;
      end
      m_pend = 0;
      if (is_push) begin
         if (m_lv && m_sp > m_lim) e_ovf = 1;
         else begin
            e_we = 1; e_addr = m_sp; e_wd = wd; m_sp = m_sp + 2;
            m_pend = first;
         end
      end else if (is_pop) begin
         if (m_sp - 2 < 16'h0800) e_unf = 1;
         else begin
            m_sp = m_sp - 2; e_re = 1; e_addr = m_sp;
         end
      end
   endtask

   task automatic compare(string tag);
      bit bad;
      bad = (ram_we_o !== e_we) || (ram_re_o !== e_re) ||
            (ovf_trap_o !== e_ovf) || (unf_trap_o !== e_unf) ||
            (busy_o !== m_pend);
      if ((e_we || e_re) && (int'(ram_addr_o) != e_addr)) bad = 1;
      if (e_we && (int'(ram_wdata_o) != e_wd)) bad = 1;
      compared++;
      if (bad) begin
         mismatched++;
         $display("FAIL %s: we/re/ovf/unf/busy=%0b%0b%0b%0b%0b addr=%h wd=%h, expected %0b%0b%0b%0b%0b addr=%h wd=%h",
                  tag, ram_we_o, ram_re_o, ovf_trap_o, unf_trap_o, busy_o,
                  ram_addr_o, ram_wdata_o, e_we, e_re, e_ovf, e_unf, m_pend,
                  e_addr[15:0], e_wd[15:0]);
      end
   endtask

   // Drive at a falling edge, clock once, compare at the next falling edge.
   task automatic cyc(string tag, bit pu, bit po, bit ca, bit ex,
                      int d, int pc, int st, bit lw, int ld);
      push_i = pu; pop_i = po; call_i = ca; exc_i = ex;
      push_data_i = 16'(d); ret_pc_i = 23'(pc); status_i = 8'(st);
      lim_we_i = lw; lim_data_i = 16'(ld);
      model_step();
      @(posedge clk);
      @(negedge clk);
      compare(tag);
   endtask

   task automatic idle(string tag);
      cyc(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         mismatched++;
         compared++;
         $display("FAIL watchdog: run hung, expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

   initial begin
      m_sp = 16'h0800; m_lv = 0; m_pend = 0; m_lim = 0; m_hi = 0;
      e_we = 0; e_re = 0; e_ovf = 0; e_unf = 0; e_addr = 0; e_wd = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      compare("R1 reset state");
      cyc("R1 first push at 0x0800", 1, 0, 0, 0, 16'h1111, 0, 0, 0, 0);
      cyc("R2 push", 1, 0, 0, 0, 16'h2222, 0, 0, 0, 0);
      cyc("R3 pop", 0, 1, 0, 0, 0, 0, 0, 0, 0);
      cyc("R3 pop", 0, 1, 0, 0, 0, 0, 0, 0, 0);
      cyc("R6 underflow", 0, 1, 0, 0, 0, 0, 0, 0, 0);
      idle("R7 pulse ends");
      cyc("R6 underflow again", 0, 1, 0, 0, 0, 0, 0, 0, 0);
      for (int i = 0; i < 5; i++)
         cyc("R5 no limit yet", 1, 0, 0, 0, 16'hA000 + i, 0, 0, 0, 0);
      // pointer now 0x080A; limit written in the same cycle as a push
      cyc("R11 same-cycle limit", 1, 0, 0, 0, 16'hBEEF, 0, 0, 1, 16'h0805);
      idle("R7 pulse ends");
      for (int i = 0; i < 3; i++) cyc("R3 pop", 0, 1, 0, 0, 0, 0, 0, 0, 0);
      cyc("R4 push at limit", 1, 0, 0, 0, 16'h4444, 0, 0, 0, 0);
      cyc("R4 push beyond limit", 1, 0, 0, 0, 16'h5555, 0, 0, 0, 0);
      cyc("R7 repeated trap", 1, 0, 0, 0, 16'h6666, 0, 0, 0, 0);
      for (int i = 0; i < 4; i++) cyc("R3 drain", 0, 1, 0, 0, 0, 0, 0, 0, 0);
      cyc("R4 raise limit", 0, 0, 0, 0, 0, 0, 0, 1, 16'h0900);
      cyc("R10 call beats push", 1, 0, 1, 0, 16'h7777, 23'h7FFFFF, 0, 0, 0);
      cyc("R8 second word, push ignored", 1, 1, 0, 0, 16'h8888, 0, 0, 0, 0);
      idle("R8 frame done");
      cyc("R9 exception", 0, 0, 0, 1, 0, 23'h551234, 8'hA5, 0, 0);
      idle("R9 status word");
      cyc("R10 exception beats call", 0, 0, 1, 1, 0, 23'h0ABCDE, 8'h3C, 0, 0);
      idle("R9 status word");
      cyc("R10 push beats pop", 1, 1, 0, 0, 16'h9999, 0, 0, 0, 0);
      cyc("R11 limit at pointer", 0, 0, 0, 0, 0, 0, 0, 1, m_sp);
      cyc("R4 call low word at limit", 0, 0, 1, 0, 0, 23'h123456, 0, 0, 0);
      idle("R4 call high word traps");
      idle("R7 pulse ends");
      cyc("R11 relax limit", 0, 0, 0, 0, 0, 0, 0, 1, 16'h0840);
      for (int i = 0; i < 400; i++) begin
         int r;
         r = $urandom_range(0, 99);
         cyc("R2 R3 random mix", r < 35, r >= 35 && r < 75, r >= 75 && r < 82,
             r >= 82 && r < 87, $urandom, $urandom, $urandom,
             r >= 96, 16'h0800 + 2 * $urandom_range(0, 40));
      end
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

endmodule